// File: doc/BRIEF.md
# Variable-Length Microinstruction Cycle Timer

This block paces a microprogrammed processor. It runs on a tick clock whose period is one quarter of the basic timing unit. On that clock it produces a set of numbered time pulses, each two units wide, and a delayed companion for each pulse that starts one unit later. The length of each cycle is chosen per microinstruction. The choices are four and a half, five, six or seven units, which is 18, 20, 24 or 28 ticks.

A stretch request asks for an extra half unit (two ticks) of pause ahead of the next time 0. This gives the following control word more time to settle. Each stretch flips a phase latch, which stands in for the latch that would invert the oscillator phase. A correction request that arrives while nothing irreversible has happened yet cuts the cycle short and reruns it from time 0. A request that arrives too late has no effect on the cycle and leaves a sticky error flag. All control pins are plain level signals. No data stream passes through the block, so it has no handshake.

Top module: `cyc_timing_gen`

## Requirements
- R1: A synchronous reset leaves the block at tick 0 of time 0: no pause, `tp_o`=4'b0001, `tpd_o`=0, and `commit_o`, `eoc_o`, `corr_o`, `late_o` and `phase_o` all 0.
- R2: The timed part of a cycle lasts 18, 20, 24 or 28 ticks for `len_sel_i` = 0, 1, 2 or 3. `eoc_o` is high on the last tick of the cycle and on no other tick.
- R3: `len_sel_i` is sampled on tick 0 of time 0 and held for the rest of the cycle. A change later in the cycle affects only the next cycle.
- R4: Counting ticks t from the start of time 0, `tp_o[k]` is high for 8k <= t < 8k+8 and `tpd_o[k]` is high for 8k+4 <= t < 8k+12. A pulse that would run past the end of the cycle is cut off there.
- R5: `stretch_i` high on an `eoc_o` tick inserts two pause ticks before the next time 0. During those ticks `pause_o` is 1 and all pulses are 0. `phase_o` toggles on each inserted pause.
- R6: `restart_i` high on a tick of the first unit of time 0 (t = 0 to 3, not during a pause) makes that tick the last tick of the cycle (`eoc_o`=1). The next cycle begins at time 0 with `corr_o`=1. `corr_o` stays high until the end of the first cycle that finishes normally.
- R7: `commit_o` is 0 on pause ticks and on ticks 0 to 3 of time 0, and 1 on every later tick of the cycle.
- R8: `restart_i` on a pause tick or at t >= 4 leaves the cycle unchanged and sets `late_o`. `late_o` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, a quarter of a basic unit |
| rst | input | 1 | Synchronous reset, active high |
| len_sel_i | input | 2 | Cycle length select: 0=18, 1=20, 2=24, 3=28 ticks |
| stretch_i | input | 1 | Request a half-unit pause before the next time 0 |
| restart_i | input | 1 | Correctable-error restart request |
| tp_o | output | 4 | Time pulses 0 to 3 |
| tpd_o | output | 4 | Delayed time pulses 0 to 3 |
| pause_o | output | 1 | Half-unit pause in progress |
| commit_o | output | 1 | Irreversible actions permitted |
| eoc_o | output | 1 | Last tick of the cycle |
| phase_o | output | 1 | Phase latch, toggled by each stretch |
| corr_o | output | 1 | Correction rerun cycle in progress |
| late_o | output | 1 | Sticky late restart error |

## Verification
Every output except `eoc_o` is decoded from registered state. A stretch, a restart or a length select therefore shows up on the tick after the clock edge that sees it. `eoc_o` answers an in-window `restart_i` within the same tick. The bench drives inputs and samples outputs one time unit after each falling edge. It checks the same-tick `eoc_o` response before it advances the clock, and it checks every other response at the next sampling point. Cycle lengths are counted tick by tick from the first tick after the previous `eoc_o`.

// File: rtl/cyc_timing_pkg.sv
package cyc_timing_pkg;
  localparam int TICKS_PER_UNIT = 4;
  localparam int HALF_TICKS     = TICKS_PER_UNIT / 2;
  localparam int PULSE_TICKS    = 2 * TICKS_PER_UNIT;
  localparam int MAX_LEN        = 14 * HALF_TICKS;
  localparam int CNT_W          = $clog2(MAX_LEN + 1);
  localparam int PAUSE_W        = $clog2(HALF_TICKS + 1);

  // Cycle length in ticks, built from the number of half units.
  function automatic int unsigned len_ticks(input logic [1:0] sel);
    case (sel)
      2'd0:    return 9  * HALF_TICKS;
      2'd1:    return 10 * HALF_TICKS;
      2'd2:    return 12 * HALF_TICKS;
      default: return 14 * HALF_TICKS;
    endcase
  endfunction
endpackage

// File: rtl/cyc_seq.sv
module cyc_seq
  import cyc_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       sel_i,
  input  logic             stretch_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] tcnt_o,
  output logic             pause_o,
  output logic             eoc_o,
  output logic             rs_take_o,
  output logic             rs_late_o
);
  logic [CNT_W-1:0]   tcnt_q, len_q;
  logic [PAUSE_W-1:0] pcnt_q;
  logic               pausing, in_win, natural_end;

  assign pausing     = (pcnt_q != '0);
  assign in_win      = !pausing && (tcnt_q < CNT_W'(TICKS_PER_UNIT));
  assign rs_take_o   = restart_i && in_win;
  assign rs_late_o   = restart_i && !in_win;
  assign natural_end = !pausing && (tcnt_q != '0) && (tcnt_q == len_q - CNT_W'(1));
  assign eoc_o       = natural_end || rs_take_o;
  assign tcnt_o      = tcnt_q;
  assign pause_o     = pausing;

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt_q <= '0;
      pcnt_q <= '0;
      len_q  <= CNT_W'(len_ticks(2'd0));
    end else if (eoc_o) begin
      tcnt_q <= '0;
      pcnt_q <= stretch_i ? PAUSE_W'(HALF_TICKS) : '0;
    end else if (pausing) begin
      pcnt_q <= pcnt_q - PAUSE_W'(1);
    end else begin
      if (tcnt_q == '0) len_q <= CNT_W'(len_ticks(sel_i));
      tcnt_q <= tcnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pulse_decode.sv
module pulse_decode
  import cyc_timing_pkg::*;
#(
  parameter int NUM_PULSES = 4
) (
  input  logic [CNT_W-1:0]      tcnt_i,
  input  logic                  pause_i,
  output logic [NUM_PULSES-1:0] tp_o,
  output logic [NUM_PULSES-1:0] tpd_o,
  output logic                  commit_o
);
  int unsigned tv;
  assign tv       = 32'(tcnt_i);
  assign commit_o = !pause_i && (tv >= TICKS_PER_UNIT);

  for (genvar k = 0; k < NUM_PULSES; k++) begin : g_pulse
    localparam int unsigned LO  = k * PULSE_TICKS;
    localparam int unsigned DLO = LO + TICKS_PER_UNIT;
    assign tp_o[k]  = !pause_i && (tv >= LO)  && (tv < LO + PULSE_TICKS);
    assign tpd_o[k] = !pause_i && (tv >= DLO) && (tv < DLO + PULSE_TICKS);
  end
endmodule

// File: rtl/cyc_flags.sv
module cyc_flags (
  input  logic clk,
  input  logic rst,
  input  logic eoc_i,
  input  logic stretch_i,
  input  logic rs_take_i,
  input  logic rs_late_i,
  output logic phase_o,
  output logic corr_o,
  output logic late_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o <= 1'b0;
      corr_o  <= 1'b0;
      late_o  <= 1'b0;
    end else begin
      if (eoc_i && stretch_i) phase_o <= !phase_o;
      if (rs_take_i)          corr_o  <= 1'b1;
      else if (eoc_i)         corr_o  <= 1'b0;
      if (rs_late_i)          late_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/cyc_timing_gen.sv
module cyc_timing_gen
  import cyc_timing_pkg::*;
#(
  parameter int NUM_PULSES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            len_sel_i,
  input  logic                  stretch_i,
  input  logic                  restart_i,
  output logic [NUM_PULSES-1:0] tp_o,
  output logic [NUM_PULSES-1:0] tpd_o,
  output logic                  pause_o,
  output logic                  commit_o,
  output logic                  eoc_o,
  output logic                  phase_o,
  output logic                  corr_o,
  output logic                  late_o
);
  logic [CNT_W-1:0] tcnt;
  logic             rs_take, rs_late;

  cyc_seq u_seq (
    .clk(clk), .rst(rst), .sel_i(len_sel_i), .stretch_i(stretch_i),
    .restart_i(restart_i), .tcnt_o(tcnt), .pause_o(pause_o), .eoc_o(eoc_o),
    .rs_take_o(rs_take), .rs_late_o(rs_late)
  );

  pulse_decode #(.NUM_PULSES(NUM_PULSES)) u_dec (
    .tcnt_i(tcnt), .pause_i(pause_o), .tp_o(tp_o), .tpd_o(tpd_o),
    .commit_o(commit_o)
  );

  cyc_flags u_flags (
    .clk(clk), .rst(rst), .eoc_i(eoc_o), .stretch_i(stretch_i),
    .rs_take_i(rs_take), .rs_late_i(rs_late), .phase_o(phase_o),
    .corr_o(corr_o), .late_o(late_o)
  );
endmodule

// File: rtl/cyc_timing_chk.sv
module cyc_timing_chk #(
  parameter int NUM_PULSES = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  stretch_i,
  input logic                  restart_i,
  input logic [NUM_PULSES-1:0] tp_o,
  input logic [NUM_PULSES-1:0] tpd_o,
  input logic                  pause_o,
  input logic                  commit_o,
  input logic                  eoc_o,
  input logic                  phase_o,
  input logic                  corr_o,
  input logic                  late_o
);
  assert_tp_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tp_o));

  assert_pause_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    pause_o |-> (tp_o == '0 && tpd_o == '0));

  assert_stretch_pause_R5: assert property (@(posedge clk) disable iff (rst)
    (eoc_o && stretch_i) |=> (pause_o && phase_o != $past(phase_o)));

  assert_plain_start_R2: assert property (@(posedge clk) disable iff (rst)
    (eoc_o && !stretch_i) |=> (tp_o[0] && !pause_o && !commit_o));

  assert_restart_ends_R6: assert property (@(posedge clk) disable iff (rst)
    (restart_i && !commit_o && !pause_o) |-> eoc_o);

  assert_restart_corr_R6: assert property (@(posedge clk) disable iff (rst)
    (restart_i && !commit_o && !pause_o) |=> corr_o);

  assert_pause_commit_R7: assert property (@(posedge clk) disable iff (rst)
    pause_o |-> !commit_o);

  assert_late_set_R8: assert property (@(posedge clk) disable iff (rst)
    (restart_i && (commit_o || pause_o)) |=> late_o);

  assert_late_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    late_o |=> late_o);
endmodule

bind cyc_timing_gen cyc_timing_chk #(.NUM_PULSES(NUM_PULSES)) u_chk (
  .clk(clk), .rst(rst), .stretch_i(stretch_i), .restart_i(restart_i),
  .tp_o(tp_o), .tpd_o(tpd_o), .pause_o(pause_o), .commit_o(commit_o),
  .eoc_o(eoc_o), .phase_o(phase_o), .corr_o(corr_o), .late_o(late_o)
);

// File: tb/sim_cyc_timing_gen.sv
module sim_cyc_timing_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] len_sel_i = 2'd0;
  logic       stretch_i = 1'b0;
  logic       restart_i = 1'b0;
  logic [3:0] tp_o, tpd_o;
  logic       pause_o, commit_o, eoc_o, phase_o, corr_o, late_o;

  int checks = 0;
  int errors = 0;

  // {sel, stretch requested at this cycle's end, expected ticks incl. pause}
  localparam logic [7:0] VEC [8] = '{
    {2'd0, 1'b0, 5'd18}, {2'd1, 1'b1, 5'd20}, {2'd2, 1'b0, 5'd26},
    {2'd3, 1'b1, 5'd28}, {2'd0, 1'b1, 5'd20}, {2'd3, 1'b0, 5'd30},
    {2'd1, 1'b0, 5'd20}, {2'd2, 1'b0, 5'd24}
  };

  cyc_timing_gen u0 (
    .clk(clk), .rst(rst), .len_sel_i(len_sel_i), .stretch_i(stretch_i),
    .restart_i(restart_i), .tp_o(tp_o), .tpd_o(tpd_o), .pause_o(pause_o),
    .commit_o(commit_o), .eoc_o(eoc_o), .phase_o(phase_o), .corr_o(corr_o),
    .late_o(late_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  function automatic logic [3:0] exp_tp(input int t);
    for (int k = 0; k < 4; k++) exp_tp[k] = (t >= 8 * k) && (t < 8 * k + 8);
  endfunction

  function automatic logic [3:0] exp_tpd(input int t);
    for (int k = 0; k < 4; k++) exp_tpd[k] = (t >= 8 * k + 4) && (t < 8 * k + 12);
  endfunction

  // Count ticks from the current one up to and including the eoc tick.
  task automatic measure(output int n);
    n = 1;
    while (!eoc_o && n < 100) begin
      step();
      n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, t, bad_shape, bad_commit, pause_seen;
    logic exp_phase;
    logic prev_st;
    repeat (3) step();
    // R1: reset state
    chk(tp_o == 4'b0001 && tpd_o == 4'b0000, "R1 pulses", int'({tp_o, tpd_o}), 8'h10);
    chk(!pause_o && !commit_o && !eoc_o, "R1 control", int'({pause_o, commit_o, eoc_o}), 0);
    chk(!corr_o && !late_o && !phase_o, "R1 flags", int'({corr_o, late_o, phase_o}), 0);
    rst = 1'b0;

    exp_phase = 1'b0;
    prev_st = 1'b0;
    // Table walk: R2 length, R3 hold, R4 shapes, R5 stretch, R7 commit
    for (int i = 0; i < 8; i++) begin
      len_sel_i = VEC[i][7:6];
      n = 1; t = 0; bad_shape = 0; bad_commit = 0; pause_seen = 0;
      while (n < 100) begin
        if (pause_o) begin
          pause_seen++;
          if (tp_o != 0 || tpd_o != 0) bad_shape++;
          if (commit_o) bad_commit++;
        end else begin
          if (tp_o != exp_tp(t) || tpd_o != exp_tpd(t)) bad_shape++;
          if (commit_o != (t >= 4)) bad_commit++;
          if (t == 5) len_sel_i = ~VEC[i][7:6]; // R3: mid-cycle change
          t++;
        end
        if (eoc_o) break;
        step();
        n++;
      end
      chk(n == int'(VEC[i][4:0]), "R2/R3 cycle length", n, int'(VEC[i][4:0]));
      chk(bad_shape == 0, "R4 pulse shape", bad_shape, 0);
      chk(bad_commit == 0, "R7 commit window", bad_commit, 0);
      chk(pause_seen == (prev_st ? 2 : 0), "R5 pause ticks", pause_seen, prev_st ? 2 : 0);
      chk(phase_o == exp_phase, "R5 phase", int'(phase_o), int'(exp_phase));
      stretch_i = VEC[i][5];
      if (VEC[i][5]) exp_phase = ~exp_phase;
      prev_st = VEC[i][5];
      step();
      stretch_i = 1'b0;
    end
    // last entry had no stretch: now at tick 0 of a new cycle
    len_sel_i = 2'd0;

    // R6: restart inside the first unit
    step(); step();
    restart_i = 1'b1;
    #1;
    chk(eoc_o == 1'b1, "R6 restart ends cycle", int'(eoc_o), 1);
    step();
    restart_i = 1'b0;
    #1;
    chk(corr_o == 1'b1, "R6 corr set", int'(corr_o), 1);
    chk(tp_o == 4'b0001 && !commit_o, "R6 back at time 0", int'(tp_o), 1);
    measure(n);
    chk(n == 18, "R6 rerun length", n, 18);
    chk(corr_o == 1'b1, "R6 corr held through rerun", int'(corr_o), 1);
    step();
    chk(corr_o == 1'b0, "R6 corr cleared", int'(corr_o), 0);

    // R8: late restart ignored, sticky flag
    for (int j = 0; j < 10; j++) step();
    restart_i = 1'b1;
    #1;
    chk(eoc_o == 1'b0, "R8 late restart no eoc", int'(eoc_o), 0);
    step();
    restart_i = 1'b0;
    #1;
    chk(late_o == 1'b1, "R8 late set", int'(late_o), 1);
    chk(corr_o == 1'b0, "R8 no corr", int'(corr_o), 0);
    measure(n);
    chk(n == 7, "R8 cycle unchanged", n, 7);
    step();
    chk(late_o == 1'b1, "R8 late sticky", int'(late_o), 1);

    // R8: restart during a pause counts as late; R1 reset clears all
    stretch_i = 1'b1;
    measure(n);
    step();
    stretch_i = 1'b0;
    chk(pause_o == 1'b1, "R5 pause after stretch", int'(pause_o), 1);
    restart_i = 1'b1;
    #1;
    chk(eoc_o == 1'b0, "R8 pause restart ignored", int'(eoc_o), 0);
    step();
    restart_i = 1'b0;
    chk(pause_o == 1'b1 && !corr_o, "R8 pause continues", int'({pause_o, corr_o}), 2);
    step(); step();
    restart_i = 1'b1;
    #1;
    step();
    restart_i = 1'b0;
    chk(corr_o == 1'b1, "R6 corr before reset", int'(corr_o), 1);
    rst = 1'b1;
    step(); step();
    chk(tp_o == 4'b0001 && !pause_o && !commit_o, "R1 reset timing", int'(tp_o), 1);
    chk(!corr_o && !late_o && !phase_o, "R1 reset flags", int'({corr_o, late_o, phase_o}), 0);
    rst = 1'b0;
    len_sel_i = 2'd3;
    measure(n);
    chk(n == 28, "R2 length after reset", n, 28);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule